// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This block is the arithmetic and logic execution stage of a small 64-bit register virtual machine used for packet filtering. Each accepted operation carries a 4-bit operation code, a flag that picks the second operand (source register or the 32-bit immediate), and a flag that picks 32-bit or 64-bit operation. The unit also receives the current destination and source register values. One clock later it presents the new destination value with a valid strobe and an illegal-operation flag.

Fetch, decode of the full opcode byte, the register file, branches and memory access live elsewhere. The surrounding pipeline writes `out_result` back to the destination register when `out_valid` is high. It should treat `out_illegal` as a trap. Division and remainder are single-cycle behavioural operators.

Top module: `pfvm_alu`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_result` and `out_illegal` change only after an accepted operation and hold their values otherwise. Reset clears all three outputs to zero.
- R2: With `src_is_reg` = 1 the second operand is `src_val`. With `src_is_reg` = 0 it is `imm_val` sign-extended to 64 bits.
- R3: With `wide_mode` = 0 the operation works on the low 32 bits of both operands and the result is zero-extended to 64 bits. With `wide_mode` = 1 all 64 bits are used.
- R4: The operation codes are add 0x0, subtract 0x1, multiply 0x2, OR 0x4, AND 0x5, XOR 0xa and move 0xb. Move returns the second operand. The others combine the destination with the second operand, wrapping modulo the operating width.
- R5: Divide (0x3) and remainder (0x9) are unsigned. Divide by zero yields 0. Remainder by zero yields the destination value, narrowed to its low 32 bits and zero-extended when `wide_mode` = 0.
- R6: Left shift (0x6), logical right shift (0x7) and arithmetic right shift (0xc) take the shift count from the second operand. The count is masked to 5 bits in 32-bit mode and to 6 bits in 64-bit mode. Arithmetic right shift fills with the sign bit of the operating width.
- R7: Negate (0x8) yields the two's-complement negation of the destination value. The second operand is ignored.
- R8: Byte-order conversion (0xd) uses `imm_val` as the width in bits, which must be 16, 32 or 64. With `src_is_reg` = 0 (to little-endian) it keeps the low width bits. With `src_is_reg` = 1 (to big-endian) it reverses the bytes of the low width bits. In both cases the result is zero-extended, and `wide_mode` has no effect.
- R9: Codes 0xe and 0xf, and byte-order conversion with any width other than 16, 32 or 64, raise `out_illegal`. In those cases `out_result` is the full 64-bit destination value unchanged. Every legal operation drives `out_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 4 | Operation code |
| src_is_reg | input | 1 | 1: source register operand; 0: immediate. Byte order selector for conversion |
| wide_mode | input | 1 | 1: 64-bit operation; 0: 32-bit operation |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Current source register value |
| imm_val | input | 32 | Immediate field |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | New destination value |
| out_illegal | output | 1 | Operation was not a legal one |

## Verification
The hardest cases to reach are those where the 32-bit and 64-bit paths part ways on the same bit pattern. Examples are a shift count above 31 that is masked only in 32-bit mode, a negative immediate that is sign-extended and then narrowed, and an arithmetic shift whose sign bit sits at bit 31 rather than bit 63. The stimulus table pairs each such pattern in both modes, with destination upper halves set to nonzero so that a missing zero-extension shows at the port. Remainder by zero in both modes, and byte-order conversion with a bad width, are driven as separate rows so that the unchanged-destination paths are told apart.

// File: rtl/pfvm_alu_pkg.sv
package pfvm_alu_pkg;

    localparam int DATA_W  = 64;
    localparam int IMM_W   = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int SHIFT_W = $clog2(DATA_W);
    localparam int BYTE_W  = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IMM_W-1:0]  imm_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc,
        OP_SWAP = 4'hd,
        OP_RSVE = 4'he,
        OP_RSVF = 4'hf
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    src_reg;
        logic    wide;
        word_t   dst;
        word_t   src;
        imm_t    imm;
    } alu_req_t;

    typedef struct packed {
        word_t value;
        logic  illegal;
    } alu_rsp_t;

    function automatic word_t sext_imm(imm_t v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic word_t zext_half(word_t v);
        return {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/pfvm_alu_operand.sv
module pfvm_alu_operand
    import pfvm_alu_pkg::*;
(
    input  alu_req_t           req,
    output word_t              opa,
    output word_t              opb,
    output logic [SHIFT_W-1:0] shamt
);

    word_t opb_raw;

    always_comb begin
        opb_raw = req.src_reg ? req.src : sext_imm(req.imm);
        opa     = req.wide ? req.dst : zext_half(req.dst);
        opb     = req.wide ? opb_raw : zext_half(opb_raw);
        if (req.wide) begin
            shamt = opb[SHIFT_W-1:0];
        end else begin
            shamt = {1'b0, opb[SHIFT_W-2:0]};
        end
    end

endmodule

// File: rtl/pfvm_alu_core.sv
module pfvm_alu_core
    import pfvm_alu_pkg::*;
(
    input  alu_op_e            op,
    input  logic               wide,
    input  word_t              opa,
    input  word_t              opb,
    input  logic [SHIFT_W-1:0] shamt,
    output alu_rsp_t           rsp
);

    word_t                     raw;
    word_t                     ar_full;
    logic signed [HALF_W-1:0]  lo_signed;
    logic signed [HALF_W-1:0]  ar_half;
    logic signed [DATA_W-1:0]  full_signed;

    always_comb begin
        full_signed = opa;
        lo_signed   = opa[HALF_W-1:0];
        ar_full     = full_signed >>> shamt;
        ar_half     = lo_signed >>> shamt;
    end

    always_comb begin
        raw         = opa;
        rsp.illegal = 1'b0;
        unique case (op)
            OP_ADD:  raw = opa + opb;
            OP_SUB:  raw = opa - opb;
            OP_MUL:  raw = opa * opb;
            OP_DIV:  raw = (opb == '0) ? '0 : opa / opb;
            OP_MOD:  raw = (opb == '0) ? opa : opa % opb;
            OP_OR:   raw = opa | opb;
            OP_AND:  raw = opa & opb;
            OP_XOR:  raw = opa ^ opb;
            OP_MOV:  raw = opb;
            OP_NEG:  raw = '0 - opa;
            OP_LSH:  raw = opa << shamt;
            OP_RSH:  raw = opa >> shamt;
            OP_ARSH: raw = wide ? ar_full : {{(DATA_W-HALF_W){1'b0}}, ar_half};
            OP_SWAP: raw = opa;
            default: rsp.illegal = 1'b1;
        endcase
        rsp.value = wide ? raw : zext_half(raw);
    end

endmodule

// File: rtl/pfvm_alu_swap.sv
module pfvm_alu_swap
    import pfvm_alu_pkg::*;
#(
    parameter int NARROW_W = 16
) (
    input  word_t    dst,
    input  logic     to_be,
    input  imm_t     width_sel,
    output alu_rsp_t rsp
);

    localparam int NB_FULL = DATA_W / BYTE_W;
    localparam int NB_HALF = HALF_W / BYTE_W;
    localparam int NB_NAR  = NARROW_W / BYTE_W;

    word_t                 rev_full;
    logic [HALF_W-1:0]     rev_half;
    logic [NARROW_W-1:0]   rev_nar;

    for (genvar i = 0; i < NB_FULL; i++) begin : g_full
        assign rev_full[BYTE_W*i +: BYTE_W] = dst[BYTE_W*(NB_FULL-1-i) +: BYTE_W];
    end

    for (genvar i = 0; i < NB_HALF; i++) begin : g_half
        assign rev_half[BYTE_W*i +: BYTE_W] = dst[BYTE_W*(NB_HALF-1-i) +: BYTE_W];
    end

    for (genvar i = 0; i < NB_NAR; i++) begin : g_nar
        assign rev_nar[BYTE_W*i +: BYTE_W] = dst[BYTE_W*(NB_NAR-1-i) +: BYTE_W];
    end

    always_comb begin
        rsp.illegal = 1'b0;
        if (width_sel == imm_t'(NARROW_W)) begin
            rsp.value = to_be ? {{(DATA_W-NARROW_W){1'b0}}, rev_nar}
                              : {{(DATA_W-NARROW_W){1'b0}}, dst[NARROW_W-1:0]};
        end else if (width_sel == imm_t'(HALF_W)) begin
            rsp.value = to_be ? {{(DATA_W-HALF_W){1'b0}}, rev_half}
                              : zext_half(dst);
        end else if (width_sel == imm_t'(DATA_W)) begin
            rsp.value = to_be ? rev_full : dst;
        end else begin
            rsp.value   = dst;
            rsp.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
    import pfvm_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op_code,
    input  logic              src_is_reg,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);

    alu_req_t           req;
    word_t              opa;
    word_t              opb;
    logic [SHIFT_W-1:0] shamt;
    alu_rsp_t           core_rsp;
    alu_rsp_t           swap_rsp;
    alu_rsp_t           sel_rsp;

    always_comb begin
        req.op      = alu_op_e'(op_code);
        req.src_reg = src_is_reg;
        req.wide    = wide_mode;
        req.dst     = dst_val;
        req.src     = src_val;
        req.imm     = imm_val;
    end

    pfvm_alu_operand u_operand (
        .req   (req),
        .opa   (opa),
        .opb   (opb),
        .shamt (shamt)
    );

    pfvm_alu_core u_core (
        .op    (req.op),
        .wide  (req.wide),
        .opa   (opa),
        .opb   (opb),
        .shamt (shamt),
        .rsp   (core_rsp)
    );

    pfvm_alu_swap #(.NARROW_W(16)) u_swap (
        .dst       (req.dst),
        .to_be     (req.src_reg),
        .width_sel (req.imm),
        .rsp       (swap_rsp)
    );

    always_comb begin
        if (req.op == OP_SWAP) begin
            sel_rsp = swap_rsp;
        end else if (core_rsp.illegal) begin
            sel_rsp.value   = req.dst;
            sel_rsp.illegal = 1'b1;
        end else begin
            sel_rsp = core_rsp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= sel_rsp.value;
                out_illegal <= sel_rsp.illegal;
            end
        end
    end

endmodule

// File: rtl/pfvm_alu_chk.sv
module pfvm_alu_chk
    import pfvm_alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic              src_is_reg,
    input logic              wide_mode,
    input logic [DATA_W-1:0] dst_val,
    input logic [DATA_W-1:0] src_val,
    input logic [IMM_W-1:0]  imm_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_illegal
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal)));

    // R3
    narrow_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode && op_code < 4'hd) |=> (out_result[DATA_W-1:HALF_W] == '0));

    // R5
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'h3 && src_is_reg && wide_mode && src_val == '0)
        |=> (out_result == '0));

    // R7
    neg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'h8 && wide_mode) |=> (out_result == '0 - $past(dst_val)));

    // R9
    reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code >= 4'he) |=> out_illegal);

    // R9
    illegal_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code >= 4'he) |=> (out_result == $past(dst_val)));

    // R9
    legal_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code < 4'hd) |=> !out_illegal);

    // R8
    swap_bad_width_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'hd && imm_val != 32'd16 && imm_val != 32'd32
         && imm_val != 32'd64) |=> out_illegal);

endmodule

bind pfvm_alu pfvm_alu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op_code     (op_code),
    .src_is_reg  (src_is_reg),
    .wide_mode   (wide_mode),
    .dst_val     (dst_val),
    .src_val     (src_val),
    .imm_val     (imm_val),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/sim_pfvm_alu.sv
module sim_pfvm_alu;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 34;
    localparam int VW = 235;

    // fields: {req 4, op 4, reg 1, wide 1, dst 64, src 64, imm 32, exp 64, ill 1}
    localparam logic [VW-1:0] VEC [NV] = '{
        // R4 add 64-bit wrap
        {4'd4, 4'h0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'h0, 64'h0, 1'b0},
        // R3 add 32-bit with nonzero upper half
        {4'd3, 4'h0, 1'b1, 1'b0, 64'h1234_5678_FFFF_FFFF, 64'h2, 32'h0, 64'h1, 1'b0},
        // R4 sub immediate 64-bit
        {4'd4, 4'h1, 1'b0, 1'b1, 64'h5, 64'h0, 32'h7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
        // R2 negative immediate sign-extended
        {4'd2, 4'h0, 1'b0, 1'b1, 64'h10, 64'h0, 32'hFFFF_FFFF, 64'hF, 1'b0},
        // R3 mul 32-bit overflow drops
        {4'd3, 4'h2, 1'b1, 1'b0, 64'h1_0000, 64'h1_0000, 32'h0, 64'h0, 1'b0},
        // R4 mul 64-bit
        {4'd4, 4'h2, 1'b1, 1'b1, 64'h1_0000, 64'h1_0000, 32'h0, 64'h1_0000_0000, 1'b0},
        // R5 div
        {4'd5, 4'h3, 1'b1, 1'b1, 64'd100, 64'd7, 32'h0, 64'd14, 1'b0},
        // R5 div by zero
        {4'd5, 4'h3, 1'b1, 1'b1, 64'd100, 64'd0, 32'h0, 64'd0, 1'b0},
        // R5 div unsigned
        {4'd5, 4'h3, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd2, 32'h0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0},
        // R5 mod
        {4'd5, 4'h9, 1'b1, 1'b1, 64'd100, 64'd7, 32'h0, 64'd2, 1'b0},
        // R5 mod by zero 64-bit
        {4'd5, 4'h9, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0001, 64'd0, 32'h0, 64'hDEAD_BEEF_0000_0001, 1'b0},
        // R5 mod by zero 32-bit
        {4'd5, 4'h9, 1'b1, 1'b0, 64'hDEAD_BEEF_0000_0009, 64'd0, 32'h0, 64'h9, 1'b0},
        // R4 or immediate
        {4'd4, 4'h4, 1'b0, 1'b1, 64'hF0, 64'h0, 32'h0F, 64'hFF, 1'b0},
        // R4 and register
        {4'd4, 4'h5, 1'b1, 1'b1, 64'hFF00_FF00_FF00_FF00, 64'h0F0F_0F0F_0F0F_0F0F, 32'h0, 64'h0F00_0F00_0F00_0F00, 1'b0},
        // R3 xor immediate 32-bit
        {4'd3, 4'ha, 1'b0, 1'b0, 64'hAAAA_AAAA_1234_5678, 64'h0, 32'hFFFF_FFFF, 64'hEDCB_A987, 1'b0},
        // R6 lsh 32-bit count 33 masked to 1
        {4'd6, 4'h6, 1'b1, 1'b0, 64'h8000_0001, 64'd33, 32'h0, 64'h2, 1'b0},
        // R6 lsh 64-bit immediate 65 masked to 1
        {4'd6, 4'h6, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'h0, 32'd65, 64'h2, 1'b0},
        // R6 rsh 64-bit
        {4'd6, 4'h7, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 32'h0, 64'h1, 1'b0},
        // R6 arsh 64-bit
        {4'd6, 4'hc, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd63, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        // R6 arsh 32-bit sign at bit 31
        {4'd6, 4'hc, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h0, 32'd4, 64'hF800_0000, 1'b0},
        // R6 rsh 32-bit zero fill
        {4'd6, 4'h7, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0, 32'd4, 64'h0800_0000, 1'b0},
        // R7 neg 64-bit, source ignored
        {4'd7, 4'h8, 1'b1, 1'b1, 64'h1, 64'h5, 32'h3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        // R7 neg 32-bit
        {4'd7, 4'h8, 1'b0, 1'b0, 64'h1, 64'h5, 32'h3, 64'hFFFF_FFFF, 1'b0},
        // R2 mov immediate 64-bit
        {4'd2, 4'hb, 1'b0, 1'b1, 64'h55, 64'h0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0},
        // R3 mov immediate 32-bit
        {4'd3, 4'hb, 1'b0, 1'b0, 64'h55, 64'h0, 32'h8000_0000, 64'h8000_0000, 1'b0},
        // R2 mov register 32-bit
        {4'd2, 4'hb, 1'b1, 1'b0, 64'h0, 64'h1122_3344_5566_7788, 32'h0, 64'h5566_7788, 1'b0},
        // R8 to-LE 16
        {4'd8, 4'hd, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 64'h7788, 1'b0},
        // R8 to-BE 16
        {4'd8, 4'hd, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 64'h8877, 1'b0},
        // R8 to-BE 32, class flag set
        {4'd8, 4'hd, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd32, 64'h8877_6655, 1'b0},
        // R8 to-BE 64, class flag clear
        {4'd8, 4'hd, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 64'h8877_6655_4433_2211, 1'b0},
        // R8 to-LE 64
        {4'd8, 4'hd, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 64'h1122_3344_5566_7788, 1'b0},
        // R9 conversion width 8 illegal
        {4'd9, 4'hd, 1'b1, 1'b0, 64'hCAFE_0000_1234_5678, 64'h0, 32'd8, 64'hCAFE_0000_1234_5678, 1'b1},
        // R9 code 0xe illegal, 32-bit mode keeps full dst
        {4'd9, 4'he, 1'b1, 1'b0, 64'hA5A5_0000_FFFF_0001, 64'h3, 32'h0, 64'hA5A5_0000_FFFF_0001, 1'b1},
        // R9 code 0xf illegal
        {4'd9, 4'hf, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h3, 32'h9, 64'h0123_4567_89AB_CDEF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        src_is_reg = 1'b0;
    logic        wide_mode = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm_val = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfvm_alu u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid), .op_code (op_code),
        .src_is_reg (src_is_reg), .wide_mode (wide_mode), .dst_val (dst_val),
        .src_val (src_val), .imm_val (imm_val), .out_valid (out_valid),
        .out_result (out_result), .out_illegal (out_illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic r, input logic w,
                         input logic [63:0] d, input logic [63:0] s, input logic [31:0] i);
        op_code = op; src_is_reg = r; wide_mode = w;
        dst_val = d; src_val = s; imm_val = i; in_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset out_valid", {63'b0, out_valid}, 64'h0);
        chk("R1 reset out_result", out_result, 64'h0);
        chk("R1 reset out_illegal", {63'b0, out_illegal}, 64'h0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k][230:227], VEC[k][226], VEC[k][225], VEC[k][224:161],
                  VEC[k][160:97], VEC[k][96:65]);
            @(negedge clk);
            in_valid = 1'b0;
            checks++;
            if (out_result !== VEC[k][64:1] || out_illegal !== VEC[k][0] || out_valid !== 1'b1) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%h/%b/%b expected=%h/%b/1",
                         VEC[k][234:231], k, out_result, out_illegal, out_valid,
                         VEC[k][64:1], VEC[k][0]);
            end
        end

        // R1 hold: idle cycles with changing inputs leave outputs alone
        @(negedge clk);
        drive(4'h0, 1'b1, 1'b1, 64'd40, 64'd2, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 add before hold", out_result, 64'd42);
        dst_val = 64'd999; op_code = 4'he;
        repeat (3) @(negedge clk);
        chk("R1 hold out_result", out_result, 64'd42);
        chk("R1 hold out_valid low", {63'b0, out_valid}, 64'h0);
        chk("R1 hold out_illegal", {63'b0, out_illegal}, 64'h0);

        // R1 back-to-back operations
        drive(4'h1, 1'b1, 1'b1, 64'd10, 64'd3, 32'h0);
        @(negedge clk);
        drive(4'hf, 1'b1, 1'b1, 64'hBEEF, 64'd3, 32'h0);
        chk("R1 back-to-back first", out_result, 64'd7);
        chk("R1 back-to-back first valid", {63'b0, out_valid}, 64'h1);
        @(negedge clk);
        drive(4'h5, 1'b0, 1'b1, 64'hFF, 64'h0, 32'h0F);
        chk("R9 back-to-back illegal value", out_result, 64'hBEEF);
        chk("R9 back-to-back illegal flag", {63'b0, out_illegal}, 64'h1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 legal clears illegal", {63'b0, out_illegal}, 64'h0);
        chk("R2 and immediate after illegal", out_result, 64'h0F);

        // R1 reset mid-stream clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears result", out_result, 64'h0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule